// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Loop Controller

This block is the digital half of a clock-and-data recovery loop that samples the line twice per bit. In each bit interval, upstream slicers deliver one sample taken at the bit centre and one taken at the boundary between that bit and the one before it. The block compares the two newest centre samples with the boundary sample between them. From that comparison it decides whether the recovery clock sits early or late. Intervals in which the data did not change give no information, and the block ignores them.

Votes are summed over a fixed window of four sample intervals. At the close of each window the block issues at most one step to an 8-bit phase code, then clears the sum. The code drives an external phase interpolator. The code is the loop's only state, so the loop is first order. The code wraps around, so the interpolator can rotate without limit. The block also passes each centre sample out, registered once, as the recovered bit.

Top module: `cdr_bb_loop`

## Requirements
- R1: Each accepted sample (`smp_valid` high at a rising edge) appears on `rx_data` with `rx_valid` high after that edge. In a cycle with no accepted sample, `rx_valid` is low after the edge.
- R2: When the new centre sample differs from the previous one, an edge sample equal to the new centre sample is a late vote (-1), and an edge sample equal to the previous centre sample is an early vote (+1).
- R3: When the new centre sample equals the previous one, there is no vote, whatever the edge sample is. The first sample after reset also gives no vote, because it has no predecessor.
- R4: Every window of four accepted samples, counted from reset, is evaluated only once its fourth sample has been accepted. Before that, the phase code does not move. The vote sum is cleared for the next window.
- R5: When a window closes, a positive vote sum raises `phase_code` by one, a negative sum lowers it by one, and a zero sum leaves it unchanged. The new value is visible after the second rising edge that follows the window's last sample.
- R6: `phase_code` wraps modulo 256: one step up from 255 gives 0, and one step down from 0 gives 255.
- R7: A synchronous active-high `rst` loads `phase_code` from `init_phase`, clears `rx_valid`, and restarts both the window count and the vote sum.
- R8: `phase_code` changes by exactly one step or not at all, and only in response to a window close.
- R9: Driven by a line whose ideal sampling phase drifts slowly, the loop follows that drift and stays within two codes of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_phase | input | 8 | Phase code loaded during reset |
| smp_valid | input | 1 | A new pair of samples is present this cycle |
| data_smp | input | 1 | Bit-centre sample |
| edge_smp | input | 1 | Boundary sample between the previous bit and this one |
| phase_code | output | 8 | Phase interpolator code |
| rx_data | output | 1 | Recovered bit |
| rx_valid | output | 1 | Recovered bit strobe |

## Verification
The recovered bit lags its sample by one rising edge. The bench checks it at the falling edge just after that rising edge, before it drives the next sample. A phase step is registered once as a decision and then once more in the code, so it lands two rising edges after the window's fourth sample. The bench idles two cycles after each window and reads the code at the falling edge that follows. For the mid-window checks, it reads the code at the same offset after only three samples, to confirm that nothing has moved early.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;

    // Phase-detector verdict for one bit interval
    typedef enum logic [1:0] {
        VOTE_NONE  = 2'b00,
        VOTE_EARLY = 2'b01,
        VOTE_LATE  = 2'b10
    } vote_e;

    // Filtered command towards the phase register
    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_UP   = 2'b01,
        STEP_DOWN = 2'b10
    } step_e;

    // One interval worth of slicer samples
    typedef struct packed {
        logic vld;
        logic data;
        logic edg;
    } smp_t;

    // Early/late decision from two centre samples and the boundary sample between them
    function automatic vote_e pd_vote(input logic prev, input logic cur, input logic edg);
        if (prev == cur)
            return VOTE_NONE;
        else if (edg == cur)
            return VOTE_LATE;
        else
            return VOTE_EARLY;
    endfunction

    // Map the sign of a window sum onto a step command
    function automatic step_e step_from_sign(input logic negative, input logic zero);
        if (zero)
            return STEP_HOLD;
        else if (negative)
            return STEP_DOWN;
        else
            return STEP_UP;
    endfunction

endpackage

// File: rtl/cdr_edge_vote.sv
`timescale 1ns/1ps
module cdr_edge_vote
    import cdr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  smp_t  smp,
    output vote_e vote,
    output logic  rx_data,
    output logic  rx_valid
);

    logic prev_q;
    logic have_prev_q;
    logic rx_valid_q;

    // Previous centre sample doubles as the recovered bit register
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
            rx_valid_q  <= 1'b0;
        end else begin
            rx_valid_q <= smp.vld;
            if (smp.vld) begin
                prev_q      <= smp.data;
                have_prev_q <= 1'b1;
            end
        end
    end

    always_comb begin
        if (smp.vld && have_prev_q)
            vote = pd_vote(prev_q, smp.data, smp.edg);
        else
            vote = VOTE_NONE;
    end

    assign rx_data  = prev_q;
    assign rx_valid = rx_valid_q;

    // R1
    rx_pipe_chk: assert property (@(posedge clk) disable iff (rst)
        smp.vld |=> (rx_valid && rx_data == $past(smp.data)));

    // R1
    rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp.vld |=> !rx_valid);

endmodule

// File: rtl/cdr_vote_filter.sv
`timescale 1ns/1ps
module cdr_vote_filter
    import cdr_pkg::*;
#(
    parameter int WIN_LEN = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  smp_vld,
    input  vote_e vote,
    output step_e step
);

    localparam int CNT_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam int ACC_W = $clog2(WIN_LEN + 1) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_LEN - 1);

    logic [CNT_W-1:0]        cnt_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] vinc;
    logic signed [ACC_W-1:0] sum_nxt;
    step_e                   step_q;

    always_comb begin
        case (vote)
            VOTE_EARLY: vinc = ACC_W'(1);
            VOTE_LATE:  vinc = -ACC_W'(1);
            default:    vinc = '0;
        endcase
        sum_nxt = acc_q + vinc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            step_q <= STEP_HOLD;
        end else begin
            step_q <= STEP_HOLD;
            if (smp_vld) begin
                if (cnt_q == LAST) begin
                    step_q <= step_from_sign(sum_nxt[ACC_W-1], sum_nxt == '0);
                    acc_q  <= '0;
                    cnt_q  <= '0;
                end else begin
                    acc_q <= sum_nxt;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign step = step_q;

    int acc_abs;
    always_comb acc_abs = (acc_q < 0) ? -int'(acc_q) : int'(acc_q);

    // R4
    acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_abs <= int'(cnt_q));

    // R8
    step_only_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        !(smp_vld && cnt_q == LAST) |=> step_q == STEP_HOLD);

endmodule

// File: rtl/cdr_phase_reg.sv
`timescale 1ns/1ps
module cdr_phase_reg
    import cdr_pkg::*;
#(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] init_phase,
    input  step_e              step,
    output logic [PHASE_W-1:0] phase
);

    logic [PHASE_W-1:0] phase_q;

    // Modulo arithmetic gives continuous rotation
    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= init_phase;
        else begin
            case (step)
                STEP_UP:   phase_q <= phase_q + 1'b1;
                STEP_DOWN: phase_q <= phase_q - 1'b1;
                default:   phase_q <= phase_q;
            endcase
        end
    end

    assign phase = phase_q;

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        step == STEP_UP |=> phase_q == PHASE_W'($past(phase_q) + 1'b1));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        step == STEP_DOWN |=> phase_q == PHASE_W'($past(phase_q) - 1'b1));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        step == STEP_HOLD |=> $stable(phase_q));

endmodule

// File: rtl/cdr_bb_loop.sv
`timescale 1ns/1ps
module cdr_bb_loop
    import cdr_pkg::*;
#(
    parameter int PHASE_W = 8,
    parameter int WIN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] init_phase,
    input  logic               smp_valid,
    input  logic               data_smp,
    input  logic               edge_smp,
    output logic [PHASE_W-1:0] phase_code,
    output logic               rx_data,
    output logic               rx_valid
);

    smp_t  smp;
    vote_e vote;
    step_e step;

    always_comb begin
        smp.vld  = smp_valid;
        smp.data = data_smp;
        smp.edg  = edge_smp;
    end

    cdr_edge_vote i_vote (
        .clk      (clk),
        .rst      (rst),
        .smp      (smp),
        .vote     (vote),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    cdr_vote_filter #(.WIN_LEN(WIN_LEN)) i_filt (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_valid),
        .vote    (vote),
        .step    (step)
    );

    cdr_phase_reg #(.PHASE_W(PHASE_W)) i_phase (
        .clk        (clk),
        .rst        (rst),
        .init_phase (init_phase),
        .step       (step),
        .phase      (phase_code)
    );

    // R3
    no_vote_flat_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && data_smp == rx_data) |-> vote == VOTE_NONE);

endmodule

// File: tb/test_cdr_bb_loop.sv
`timescale 1ns/1ps
module test_cdr_bb_loop;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] init_phase = 8'h00;
    logic       smp_valid = 1'b0;
    logic       data_smp = 1'b0;
    logic       edge_smp = 1'b0;
    logic [7:0] phase_code;
    logic       rx_data;
    logic       rx_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // bench-side model state
    bit   pend = 1'b0;
    logic pend_d = 1'b0;
    logic prev = 1'b0;
    bit   have_prev = 1'b0;
    int   wcnt = 0;
    int   wsum = 0;
    logic [7:0] exp_phase = 8'h00;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    cdr_bb_loop i_cdr_bb_loop (
        .clk        (clk),
        .rst        (rst),
        .init_phase (init_phase),
        .smp_valid  (smp_valid),
        .data_smp   (data_smp),
        .edge_smp   (edge_smp),
        .phase_code (phase_code),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_rx();
        if (pend) begin
            check_eq("R1 rx_valid", int'(rx_valid), 1);
            check_eq("R1 rx_data", int'(rx_data), int'(pend_d));
        end else begin
            check_eq("R1 rx_valid idle", int'(rx_valid), 0);
        end
    endtask

    task automatic send(input logic d, input logic e);
        @(negedge clk);
        check_rx();
        smp_valid = 1'b1;
        data_smp  = d;
        edge_smp  = e;
        pend      = 1'b1;
        pend_d    = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_rx();
            smp_valid = 1'b0;
            pend      = 1'b0;
        end
    endtask

    // account one interval in the bench's window model
    task automatic count_vote(input int v);
        wsum += v;
        wcnt++;
        if (wcnt == 4) begin
            if (wsum > 0) exp_phase = exp_phase + 8'd1;
            else if (wsum < 0) exp_phase = exp_phase - 8'd1;
            wcnt = 0;
            wsum = 0;
        end
    endtask

    // kind: 0 none, 1 early, 2 late
    task automatic send_vote(input int kind, input logic filler);
        logic d;
        logic e;
        int   v;
        v = 0;
        if (kind == 1) begin
            d = ~prev; e = prev; v = 1;
        end else if (kind == 2) begin
            d = ~prev; e = ~prev; v = -1;
        end else begin
            d = prev; e = filler;
        end
        send(d, e);
        prev = d;
        count_vote(v);
    endtask

    task automatic do_reset(input logic [7:0] init);
        @(negedge clk);
        rst        = 1'b1;
        smp_valid  = 1'b0;
        init_phase = init;
        pend       = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_eq("R7 phase after reset", int'(phase_code), int'(init));
        check_eq("R7 rx_valid after reset", int'(rx_valid), 0);
        exp_phase = init;
        wcnt = 0;
        wsum = 0;
        have_prev = 1'b0;
    endtask

    // First window after reset: first sample would look late if it had a predecessor (R3)
    task automatic primer();
        send(1'b1, 1'b1);
        count_vote(0);
        for (int i = 0; i < 3; i++) begin
            send(1'b1, i[0]);
            count_vote(0);
        end
        prev = 1'b1;
        have_prev = 1'b1;
        idle(2);
        check_eq("R3 no vote on first sample after reset", int'(phase_code), int'(exp_phase));
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // Line model: ideal sampling phase at code tgt
    task automatic track_window(input logic [7:0] tgt);
        for (int i = 0; i < 4; i++) begin
            logic d;
            logic e;
            logic signed [7:0] diff;
            d = next_bit() ^ lfsr[3];
            diff = $signed(tgt - phase_code);
            if (d == prev) e = lfsr[5];
            else if (diff > 0) e = prev;
            else if (diff < 0) e = d;
            else e = lfsr[7];
            send(d, e);
            prev = d;
        end
    endtask

    task automatic check_track(input logic [7:0] tgt);
        logic signed [7:0] diff;
        int ad;
        diff = $signed(tgt - phase_code);
        ad = (diff < 0) ? -int'(diff) : int'(diff);
        checks++;
        if (ad > 2) begin
            errors++;
            $display("FAIL R9 tracking actual=%0d expected=%0d (+/-2)", phase_code, tgt);
        end
    endtask

    initial begin
        logic [7:0] tgt;
        do_reset(8'h80);

        // R3: first sample after reset gives no vote
        primer();

        // R4: three early votes alone do not move the code
        for (int i = 0; i < 3; i++) send_vote(1, 1'b0);
        idle(2);
        check_eq("R4 no step before window close", int'(phase_code), 8'h80);
        send_vote(1, 1'b0);
        idle(2);
        check_eq("R4 R5 step after fourth sample", int'(phase_code), 8'h81);

        // R2 R5: all 81 vote patterns over one window
        for (int p = 0; p < 81; p++) begin
            int r;
            r = p;
            for (int k = 0; k < 4; k++) begin
                send_vote(r % 3, p[k]);
                r = r / 3;
            end
            idle(2);
            check_eq("R2 R5 window decision", int'(phase_code), int'(exp_phase));
        end

        // R3: long run with no transitions and varied edge samples
        for (int w = 0; w < 16; w++) begin
            for (int k = 0; k < 4; k++) send_vote(0, next_bit());
            idle(2);
            check_eq("R3 no move without transitions", int'(phase_code), int'(exp_phase));
        end

        // R6: wrap upward
        do_reset(8'hFF);
        primer();
        for (int k = 0; k < 4; k++) send_vote(1, 1'b0);
        idle(2);
        check_eq("R6 wrap 255 to 0", int'(phase_code), 0);

        // R6: wrap downward
        do_reset(8'h00);
        primer();
        for (int k = 0; k < 4; k++) send_vote(2, 1'b0);
        idle(2);
        check_eq("R6 wrap 0 to 255", int'(phase_code), 255);

        // R9: lock, then follow slow drift both ways
        do_reset(8'h10);
        primer();
        tgt = 8'h30;
        for (int w = 0; w < 80; w++) track_window(tgt);
        check_track(tgt);
        for (int w = 0; w < 200; w++) begin
            if (w % 8 == 7) tgt = tgt + 8'd1;
            track_window(tgt);
            if (w % 40 == 39) check_track(tgt);
        end
        for (int w = 0; w < 400; w++) begin
            if (w % 8 == 7) tgt = tgt - 8'd1;
            track_window(tgt);
            if (w % 40 == 39) check_track(tgt);
        end
        idle(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule